// File: doc/BRIEF.md
# Timer Input Capture Unit

This block takes a timestamp from a free-running timer. When the chosen edge arrives on an asynchronous capture pin, the block copies the timer's counter value into a capture register. It also raises a sticky flag. The flag produces an interrupt request when the interrupt enable is high. Software clears the flag in one of two ways: it writes a one to the clear strobe, or the interrupt controller returns an acknowledge pulse.

The capture register can also serve as the timer's TOP value. While that mode is active, the capture pin has no effect: no edge loads the register and no edge touches the flag. Software then loads the register directly through a write port. The counter, the waveform generator and any input filtering live outside this block.

Top module: `icu_capture_unit`

## Requirements
- R1: With `edge_rise` = 1, a 0-to-1 transition of `cap_pin` triggers a capture. With `edge_rise` = 0, a 1-to-0 transition triggers it. A transition in the other direction triggers nothing.
- R2: The pin passes through a two-flop synchronizer. Suppose a pin change is set up before clock edge k. Then the capture register takes the `cnt_value` present at edge k+2, and shows it after that edge. At edges k and k+1 neither the register nor the flag changes.
- R3: Every capture sets `cap_flag` at the same edge that loads `cap_value`.
- R4: `irq_req` is high exactly when `cap_flag` and `irq_en` are both high.
- R5: While `top_mode` is high, pin transitions cause no capture and leave `cap_flag` unchanged.
- R6: A one on `flag_clr` or on `irq_ack` clears `cap_flag` at the next edge. If a capture falls in the same cycle as a clear, the flag is set.
- R7: While `top_mode` is high, `sw_wr_en` loads `sw_wr_data` into `cap_value` at the next edge. While `top_mode` is low, software writes are ignored.
- R8: After reset, `cap_value` is 0, `cap_flag` is 0 and `irq_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_pin | input | 1 | Asynchronous capture input |
| edge_rise | input | 1 | 1 selects the rising edge, 0 selects the falling edge |
| cnt_value | input | 16 | Current timer counter value |
| top_mode | input | 1 | Capture register is in use as the counter TOP |
| irq_en | input | 1 | Capture interrupt enable |
| sw_wr_en | input | 1 | Software write strobe for the capture register |
| sw_wr_data | input | 16 | Software write data |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| cap_value | output | 16 | Capture register |
| cap_flag | output | 1 | Sticky capture flag |
| irq_req | output | 1 | Capture interrupt request |

## Verification
The bench tries every combination of edge polarity, transition direction, TOP mode and interrupt enable. This separates three things:
- a correct trigger from the opposite polarity;
- a capture from the suppression in TOP mode;
- an interrupt request from a flag that is merely set.

The counter steps by seven each cycle and wraps through zero. As a result, an off-by-one in the synchronizer latency shows up as a wrong captured value, and a check two cycles after the pin change confirms that nothing changes early. Clear strobes are placed both in a quiet cycle and in the exact cycle of a capture, and software writes are issued with TOP mode both on and off.

// File: rtl/icu_pkg.sv
// Package: types shared by the input capture unit.
// Assumes: nothing beyond standard SystemVerilog.
package icu_pkg;
    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_sel_e;
endpackage

// File: rtl/icu_edge_detect.sv
// Module: synchronizes the asynchronous capture pin and reports one event
//         per selected edge, only while enabled.
// Assumes: STAGES >= 2. The pin is held low while reset is applied.
module icu_edge_detect
    import icu_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_i,
    input  edge_sel_e edge_sel_i,
    input  logic      enable_i,
    output logic      event_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              synced;

    // Shift the pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], pin_i};
    end

    assign synced = sync_q[STAGES-1];

    // Keep the last synchronized level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= synced;
    end

    // Pick the polarity and gate the event with the enable.
    always_comb begin
        if (edge_sel_i == EDGE_RISE) event_o = enable_i &  synced & ~prev_q;
        else                         event_o = enable_i & ~synced &  prev_q;
    end
endmodule

// File: rtl/icu_capture_reg.sv
// Module: capture register. It loads the counter on an event, or
//         software data while in TOP mode.
// Assumes: the event is already suppressed by the caller in TOP mode.
module icu_capture_reg #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_evt_i,
    input  logic [WIDTH-1:0] cnt_i,
    input  logic             top_mode_i,
    input  logic             wr_en_i,
    input  logic [WIDTH-1:0] wr_data_i,
    output logic [WIDTH-1:0] value_o
);
    // Load on capture first, otherwise on a software write in TOP mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                     value_o <= '0;
        else if (cap_evt_i)             value_o <= cnt_i;
        else if (top_mode_i && wr_en_i) value_o <= wr_data_i;
    end

    a_r2_capture_loads: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt_i |=> value_o == $past(cnt_i));

    a_r7_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_evt_i && !top_mode_i) |=> value_o == $past(value_o));

    a_r5_top_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (top_mode_i && !wr_en_i) |=> value_o == $past(value_o));
endmodule

// File: rtl/icu_flag_ctrl.sv
// Module: sticky capture flag with two clear sources, and the interrupt
//         request built from it.
// Assumes: a set takes priority over a clear in the same cycle.
module icu_flag_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic ack_i,
    input  logic irq_en_i,
    output logic flag_o,
    output logic irq_o
);
    // Update the flag: set wins over either clear.
    always_ff @(posedge clk) begin
        if (!rst_n)              flag_o <= 1'b0;
        else if (set_i)          flag_o <= 1'b1;
        else if (clr_i || ack_i) flag_o <= 1'b0;
    end

    // Request an interrupt while the flag is set and enabled.
    assign irq_o = flag_o & irq_en_i;

    a_r3_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    a_r6_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && (clr_i || ack_i)) |=> !flag_o);

    a_r6_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i && !ack_i) |=> flag_o == $past(flag_o));
endmodule

// File: rtl/icu_capture_unit.sv
// Module: top of the input capture unit. It joins the edge detector, the
//         capture register and the flag controller.
// Assumes: cnt_value is synchronous to clk. In TOP mode the pin is ignored.
module icu_capture_unit
    import icu_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_pin,
    input  logic             edge_rise,
    input  logic [CNT_W-1:0] cnt_value,
    input  logic             top_mode,
    input  logic             irq_en,
    input  logic             sw_wr_en,
    input  logic [CNT_W-1:0] sw_wr_data,
    input  logic             flag_clr,
    input  logic             irq_ack,
    output logic [CNT_W-1:0] cap_value,
    output logic             cap_flag,
    output logic             irq_req
);
    logic      cap_evt;
    edge_sel_e edge_sel;

    assign edge_sel = edge_sel_e'(edge_rise);

    icu_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (cap_pin),
        .edge_sel_i(edge_sel),
        .enable_i  (!top_mode),
        .event_o   (cap_evt)
    );

    icu_capture_reg #(.WIDTH(CNT_W)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_evt_i (cap_evt),
        .cnt_i     (cnt_value),
        .top_mode_i(top_mode),
        .wr_en_i   (sw_wr_en),
        .wr_data_i (sw_wr_data),
        .value_o   (cap_value)
    );

    icu_flag_ctrl u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (cap_evt),
        .clr_i   (flag_clr),
        .ack_i   (irq_ack),
        .irq_en_i(irq_en),
        .flag_o  (cap_flag),
        .irq_o   (irq_req)
    );

    a_r4_irq_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_flag && irq_en) |-> irq_req);

    a_r5_top_flag_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (top_mode && !flag_clr && !irq_ack) |=> cap_flag == $past(cap_flag));
endmodule

// File: tb/test_icu_capture_unit.sv
`timescale 1ns/1ps
module test_icu_capture_unit;
    localparam logic [15:0] STEP = 16'd7;

    logic        clk = 1'b0;
    logic        rst_n, cap_pin, edge_rise, top_mode, irq_en;
    logic        sw_wr_en, flag_clr, irq_ack;
    logic [15:0] sw_wr_data;
    logic [15:0] cnt_value = 16'hFF00;
    logic [15:0] cap_value;
    logic        cap_flag, irq_req;
    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;
    logic [15:0] model_cap = 16'h0;

    icu_capture_unit i_icu_capture_unit (
        .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .edge_rise(edge_rise),
        .cnt_value(cnt_value), .top_mode(top_mode), .irq_en(irq_en),
        .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data), .flag_clr(flag_clr),
        .irq_ack(irq_ack), .cap_value(cap_value), .cap_flag(cap_flag),
        .irq_req(irq_req)
    );

    always #2.5 clk = ~clk;

    // Free-running counter, stepped away from the active edge.
    always @(negedge clk) cnt_value <= cnt_value + STEP;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic tick;
        @(negedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Toggle the pin so that the selected edge fires; return the expected capture.
    task automatic make_edge(output logic [15:0] exp_cap);
        edge_rise = ~cap_pin;
        tick;
        cap_pin = ~cap_pin;
        exp_cap = cnt_value + 16'(2 * STEP);
    endtask

    initial begin
        logic [15:0] c;
        logic [15:0] e;
        rst_n = 0; cap_pin = 0; edge_rise = 0; top_mode = 0; irq_en = 0;
        sw_wr_en = 0; sw_wr_data = 0; flag_clr = 0; irq_ack = 0;
        repeat (3) tick;
        rst_n = 1;
        tick;
        check(cap_value == 16'h0, "R8", "cap_value after reset", cap_value, 0);
        check(cap_flag == 1'b0, "R8", "flag after reset", cap_flag, 0);
        check(irq_req == 1'b0, "R8", "irq after reset", irq_req, 0);

        // Sweep: polarity x TOP mode x enable x transition direction (R1 R2 R3 R4 R5).
        for (int es = 0; es < 2; es++)
            for (int tm = 0; tm < 2; tm++)
                for (int ie = 0; ie < 2; ie++)
                    for (int dir = 0; dir < 2; dir++) begin
                        bit trig;
                        edge_rise = es[0]; irq_en = ie[0];
                        top_mode = 1; cap_pin = dir[0];
                        repeat (4) tick;
                        top_mode = tm[0]; flag_clr = 1;
                        tick;
                        flag_clr = 0;
                        cap_pin = ~dir[0];
                        c = cnt_value;
                        trig = (tm == 0) && ((dir == 0) == (es == 1));
                        tick; tick;
                        check(cap_flag == 1'b0, "R2", "flag before latency", cap_flag, 0);
                        check(cap_value == model_cap, "R2", "value before latency", cap_value, model_cap);
                        tick;
                        e = trig ? c + 16'(2 * STEP) : model_cap;
                        check(cap_value == e, trig ? "R1" : (tm != 0 ? "R5" : "R1"),
                              "cap_value after edge", cap_value, e);
                        check(cap_flag == trig, tm != 0 ? "R5" : "R3", "flag after edge",
                              cap_flag, trig);
                        check(irq_req == (trig && ie != 0), "R4", "irq_req", irq_req,
                              trig && ie != 0);
                        model_cap = e;
                    end
        top_mode = 0; irq_en = 1;

        // R6: write-one-to-clear in a quiet cycle.
        make_edge(e); repeat (3) tick;
        check(cap_flag == 1'b1, "R3", "flag set", cap_flag, 1);
        flag_clr = 1; tick; flag_clr = 0;
        check(cap_flag == 1'b0, "R6", "flag after w1c", cap_flag, 0);
        check(irq_req == 1'b0, "R4", "irq after w1c", irq_req, 0);

        // R6: acknowledge clears.
        make_edge(e); repeat (3) tick;
        irq_ack = 1; tick; irq_ack = 0;
        check(cap_flag == 1'b0, "R6", "flag after ack", cap_flag, 0);

        // R6: set wins over a clear in the capture cycle.
        make_edge(e); tick; tick;
        flag_clr = 1; tick; flag_clr = 0;
        check(cap_flag == 1'b1, "R6", "set wins over w1c", cap_flag, 1);
        check(cap_value == e, "R2", "value on clear cycle", cap_value, e);
        flag_clr = 1; tick; flag_clr = 0;
        make_edge(e); tick; tick;
        irq_ack = 1; tick; irq_ack = 0;
        check(cap_flag == 1'b1, "R6", "set wins over ack", cap_flag, 1);
        model_cap = e;

        // R7: software writes in TOP mode load; outside TOP mode they are ignored.
        for (int i = 0; i < 6; i++) begin
            logic [15:0] d;
            d = 16'(i * 16'h2493) ^ 16'hA5C3;
            top_mode = 1; sw_wr_en = 1; sw_wr_data = d;
            tick;
            sw_wr_en = 0;
            check(cap_value == d, "R7", "write in TOP mode", cap_value, d);
            top_mode = 0; sw_wr_en = 1; sw_wr_data = ~d;
            tick;
            sw_wr_en = 0;
            check(cap_value == d, "R7", "write outside TOP mode", cap_value, d);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule